// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

A synchronous single-port memory with registered inputs and a registered read path, shaped after the bus of a pipelined burst cache SRAM. Every rising clock edge captures the address, the write data, the three chip selects, the two cycle-start strobes, the advance input and the write controls. One clock later the captured command acts on the array: a write updates the selected byte lanes, and a read loads the addressed word into an output register. Read data therefore shows at the port after the second rising edge that follows the presented command.

A cycle starts on one of two strobes. The host strobe only counts while the first select is active. The control strobe always counts and takes the write controls of its own cycle into account. Between starts, the advance input steps a 2-bit burst offset, in linear or interleaved order, over the address captured at the start. A start with a failing chip select is a deselect. After a deselect that follows read data, the output register keeps driving for one more cycle before it releases the bus. The output enable acts asynchronously on the drive signal. The data bus is split into a write-data input, a read-data output and a drive flag that models high impedance (read data reads zero while not driven). The interface is a plain synchronous bus with no valid/ready flow control and no back-pressure: every cycle takes one command.

Top module: `sbs_sram_core`

## Requirements
- R1: After reset `rdata_drive` is 0 and `rdata` is 0 until a read completes.
- R2: A read presented before edge k makes `rdata_drive` 1 with the addressed word on `rdata` after edge k+1, with `out_en_n` low.
- R3: With `lane_wmaster_n` low, `all_we_n` high and `lane_we_n` 2'b00 on a control-strobe start, all 18 bits of the addressed word are written.
- R4: Lane A is `rdata[8:0]`, enabled by `lane_we_n[0]`; lane B is `rdata[17:9]`, enabled by `lane_we_n[1]`. With the master low, only lanes whose enable is low change.
- R5: `all_we_n` low writes every lane, whatever `lane_we_n` and `lane_wmaster_n` hold.
- R6: With `all_we_n` and `lane_wmaster_n` both high, the cycle is a read and the array is not changed.
- R7: The `addr` input is ignored in cycles with neither strobe active; such a cycle acts on the burst address held from the last start.
- R8: A host-strobe start while `sel0_n` is high is ignored: the running burst continues as if no strobe were present.
- R9: A cycle started by the host strobe is always a read, even with write controls active.
- R10: `advance_n` low steps the 2-bit offset. With `burst_order` 0 the low address bits are base plus offset modulo 4; with 1 they are base XOR offset.
- R11: A deselect (start with `sel0_n`=0, `sel1`=1, `sel2_n`=0 not all true) right after read data keeps the drive and the data for exactly one more cycle; the cycle after that the drive is off.
- R12: `out_en_n` high clears `rdata_drive` and zeroes `rdata` at once, without waiting for a clock edge.
- R13: After a write cycle the output is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW (6) | Word address, captured on a start |
| wdata | input | DW (18) | Write data, two 9-bit lanes |
| sel0_n | input | 1 | First chip select, active low, also gates the host strobe |
| sel1 | input | 1 | Second chip select, active high |
| sel2_n | input | 1 | Third chip select, active low |
| host_strobe_n | input | 1 | Cycle start from the host, active low |
| ctrl_strobe_n | input | 1 | Cycle start from the controller, active low |
| advance_n | input | 1 | Step the burst offset, active low |
| burst_order | input | 1 | 0 linear, 1 interleaved; held static while a burst runs |
| lane_we_n | input | LANES (2) | Per-lane write enable, active low |
| lane_wmaster_n | input | 1 | Qualifies the lane enables, active low |
| all_we_n | input | 1 | Write every lane, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DW (18) | Read data, zero while not driven |
| rdata_drive | output | 1 | Bus-drive flag (1 = driven, 0 = high impedance) |

## Verification
A wrong burst counter or a stale held base address shows as a wrong word on `rdata` two edges after the cycle that used it, so the bench reads every burst step back through plain single reads. A wrong write-lane decode only appears when the damaged word is read again later, which is why every write is checked through a read of the same address. An error in the drive-extension state shows on `rdata_drive` after the first or second edge following a deselect, and a wrong write/read decision shows either as drive during a write slot or as a word that changed when it should not have.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_DESEL = 2'd3
  } sbs_op_e;

  localparam int SBS_LANE_W = 9;
  localparam int SBS_LANES  = 2;
  localparam int SBS_BURST_W = 2;

endpackage

// File: rtl/sbs_in_reg.sv
module sbs_in_reg #(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int DW    = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             sel0_n,
  input  logic             sel1,
  input  logic             sel2_n,
  input  logic             host_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             advance_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             lane_wmaster_n,
  input  logic             all_we_n,
  output logic [AW-1:0]    r_addr,
  output logic [DW-1:0]    r_wdata,
  output logic             r_sel0_n,
  output logic             r_sel1,
  output logic             r_sel2_n,
  output logic             r_host_n,
  output logic             r_ctrl_n,
  output logic             r_adv_n,
  output logic [LANES-1:0] r_lane_n,
  output logic             r_master_n,
  output logic             r_all_n
);

  // Every synchronous input passes one register; controls reset to idle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_addr     <= '0;
      r_wdata    <= '0;
      r_sel0_n   <= 1'b1;
      r_sel1     <= 1'b0;
      r_sel2_n   <= 1'b1;
      r_host_n   <= 1'b1;
      r_ctrl_n   <= 1'b1;
      r_adv_n    <= 1'b1;
      r_lane_n   <= '1;
      r_master_n <= 1'b1;
      r_all_n    <= 1'b1;
    end else begin
      r_addr     <= addr;
      r_wdata    <= wdata;
      r_sel0_n   <= sel0_n;
      r_sel1     <= sel1;
      r_sel2_n   <= sel2_n;
      r_host_n   <= host_strobe_n;
      r_ctrl_n   <= ctrl_strobe_n;
      r_adv_n    <= advance_n;
      r_lane_n   <= lane_we_n;
      r_master_n <= lane_wmaster_n;
      r_all_n    <= all_we_n;
    end
  end

endmodule

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          order,
  input  logic [BW-1:0] base_lo,
  output logic [BW-1:0] ofs
);

  logic [BW-1:0] cnt_q;
  logic [BW-1:0] cnt_d;

  // The offset used in a cycle already includes that cycle's step.
  always_comb begin
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  assign ofs = order ? (base_lo ^ cnt_d) : (base_lo + cnt_d);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sbs_cycle_ctl.sv
module sbs_cycle_ctl
  import sbs_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    r_addr,
  input  logic             r_sel0_n,
  input  logic             r_sel1,
  input  logic             r_sel2_n,
  input  logic             r_host_n,
  input  logic             r_ctrl_n,
  input  logic             r_adv_n,
  input  logic [LANES-1:0] r_lane_n,
  input  logic             r_master_n,
  input  logic             r_all_n,
  input  logic             burst_order,
  output sbs_op_e          op,
  output logic [AW-1:0]    eff_addr,
  output logic [LANES-1:0] lane_mask
);

  logic            act_q;
  logic [AW-1:0]   base_q;
  logic            host_go;
  logic            start;
  logic            selected;
  logic            live;
  logic            step;
  logic [AW-1:0]   base_sel;
  logic [BW-1:0]   ofs;
  logic [LANES-1:0] mask_raw;
  logic            wr;

  assign host_go  = !r_host_n && !r_sel0_n;
  assign start    = host_go || !r_ctrl_n;
  assign selected = !r_sel0_n && r_sel1 && !r_sel2_n;
  assign live     = start ? selected : act_q;
  assign step     = !start && act_q && !r_adv_n;
  assign base_sel = start ? r_addr : base_q;

  sbs_burst_gen #(.BW(BW)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .step    (step),
    .order   (burst_order),
    .base_lo (base_sel[BW-1:0]),
    .ofs     (ofs)
  );

  assign eff_addr = {base_sel[AW-1:BW], ofs};

  always_comb begin
    if (!r_all_n)         mask_raw = '1;
    else if (!r_master_n) mask_raw = ~r_lane_n;
    else                  mask_raw = '0;
  end

  // Host-strobe starts never write.
  assign wr        = live && !host_go && (|mask_raw);
  assign lane_mask = wr ? mask_raw : '0;

  always_comb begin
    if (!live)   op = start ? OP_DESEL : OP_IDLE;
    else if (wr) op = OP_WRITE;
    else         op = OP_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
    end else if (start) begin
      act_q  <= selected;
      base_q <= r_addr;
    end
  end

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
  parameter int AW     = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DW     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic [LANES-1:0] we,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wd,
  output logic [DW-1:0]    rd
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) lane_mem[addr] <= wd[g*LANE_W +: LANE_W];
    end

    assign rd[g*LANE_W +: LANE_W] = lane_mem[addr];
  end

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage
  import sbs_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sbs_op_e       op,
  input  logic [DW-1:0] rd_word,
  input  logic          out_en_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_drive,
  output logic          drv_o
);

  logic [DW-1:0] data_q;
  logic          drv_q;
  logic          ext_q;

  // Second drive stage: one deselect after read data keeps the bus once.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      drv_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else if (op == OP_READ) begin
      data_q <= rd_word;
      drv_q  <= 1'b1;
      ext_q  <= 1'b0;
    end else if (op == OP_DESEL && drv_q && !ext_q) begin
      drv_q  <= 1'b1;
      ext_q  <= 1'b1;
    end else begin
      drv_q  <= 1'b0;
      ext_q  <= 1'b0;
    end
  end

  assign drv_o       = drv_q;
  assign rdata_drive = drv_q && !out_en_n;
  assign rdata       = rdata_drive ? data_q : '0;

endmodule

// File: rtl/sbs_sram_core.sv
module sbs_sram_core
  import sbs_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANE_W = SBS_LANE_W,
  parameter int LANES  = SBS_LANES,
  parameter int BW     = SBS_BURST_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic [LANE_W*LANES-1:0]   wdata,
  input  logic                      sel0_n,
  input  logic                      sel1,
  input  logic                      sel2_n,
  input  logic                      host_strobe_n,
  input  logic                      ctrl_strobe_n,
  input  logic                      advance_n,
  input  logic                      burst_order,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic                      lane_wmaster_n,
  input  logic                      all_we_n,
  input  logic                      out_en_n,
  output logic [LANE_W*LANES-1:0]   rdata,
  output logic                      rdata_drive
);

  localparam int DW = LANE_W * LANES;

  logic [AW-1:0]    r_addr;
  logic [DW-1:0]    r_wdata;
  logic             r_sel0_n, r_sel1, r_sel2_n;
  logic             r_host_n, r_ctrl_n, r_adv_n;
  logic [LANES-1:0] r_lane_n;
  logic             r_master_n, r_all_n;

  sbs_op_e          op_w;
  logic [AW-1:0]    eff_addr_w;
  logic [LANES-1:0] lane_mask_w;
  logic [DW-1:0]    rd_word_w;
  logic             drv_w;

  sbs_in_reg #(.AW(AW), .LANES(LANES), .DW(DW)) u_in (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr           (addr),
    .wdata          (wdata),
    .sel0_n         (sel0_n),
    .sel1           (sel1),
    .sel2_n         (sel2_n),
    .host_strobe_n  (host_strobe_n),
    .ctrl_strobe_n  (ctrl_strobe_n),
    .advance_n      (advance_n),
    .lane_we_n      (lane_we_n),
    .lane_wmaster_n (lane_wmaster_n),
    .all_we_n       (all_we_n),
    .r_addr         (r_addr),
    .r_wdata        (r_wdata),
    .r_sel0_n       (r_sel0_n),
    .r_sel1         (r_sel1),
    .r_sel2_n       (r_sel2_n),
    .r_host_n       (r_host_n),
    .r_ctrl_n       (r_ctrl_n),
    .r_adv_n        (r_adv_n),
    .r_lane_n       (r_lane_n),
    .r_master_n     (r_master_n),
    .r_all_n        (r_all_n)
  );

  sbs_cycle_ctl #(.AW(AW), .LANES(LANES), .BW(BW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .r_addr      (r_addr),
    .r_sel0_n    (r_sel0_n),
    .r_sel1      (r_sel1),
    .r_sel2_n    (r_sel2_n),
    .r_host_n    (r_host_n),
    .r_ctrl_n    (r_ctrl_n),
    .r_adv_n     (r_adv_n),
    .r_lane_n    (r_lane_n),
    .r_master_n  (r_master_n),
    .r_all_n     (r_all_n),
    .burst_order (burst_order),
    .op          (op_w),
    .eff_addr    (eff_addr_w),
    .lane_mask   (lane_mask_w)
  );

  sbs_mem_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES), .DW(DW)) u_mem (
    .clk  (clk),
    .we   (lane_mask_w),
    .addr (eff_addr_w),
    .wd   (r_wdata),
    .rd   (rd_word_w)
  );

  sbs_out_stage #(.DW(DW)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op_w),
    .rd_word     (rd_word_w),
    .out_en_n    (out_en_n),
    .rdata       (rdata),
    .rdata_drive (rdata_drive),
    .drv_o       (drv_w)
  );

endmodule

// File: rtl/sbs_sram_checker.sv
module sbs_sram_checker
  import sbs_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel0_n,
  input logic             sel1,
  input logic             sel2_n,
  input logic             host_strobe_n,
  input logic             ctrl_strobe_n,
  input logic [LANES-1:0] lane_we_n,
  input logic             lane_wmaster_n,
  input logic             all_we_n,
  input sbs_op_e          op,
  input logic [LANES-1:0] lane_mask,
  input logic             drv
);

  logic sel_ok;
  logic ctrl_only;
  assign sel_ok    = !sel0_n && sel1 && !sel2_n;
  assign ctrl_only = !ctrl_strobe_n && host_strobe_n && sel_ok;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !drv);  // R1

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) |=> drv);  // R2

  AST_LANE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_only && all_we_n && !lane_wmaster_n) |=> (lane_mask == ~$past(lane_we_n)));  // R4

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_only && !all_we_n) |=> (op == OP_WRITE && lane_mask == '1));  // R5

  AST_NO_MASTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_only && all_we_n && lane_wmaster_n) |=> (op == OP_READ));  // R6

  AST_HOST_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_strobe_n && !sel0_n) |=> (op != OP_WRITE));  // R9

  AST_DESEL_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_READ) ##1 (op == OP_DESEL) |=> drv);  // R11

  AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) ##1 (op == OP_DESEL) |=> !drv);  // R11

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |=> !drv);  // R13

endmodule

bind sbs_sram_core sbs_sram_checker #(.LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sel0_n         (sel0_n),
  .sel1           (sel1),
  .sel2_n         (sel2_n),
  .host_strobe_n  (host_strobe_n),
  .ctrl_strobe_n  (ctrl_strobe_n),
  .lane_we_n      (lane_we_n),
  .lane_wmaster_n (lane_wmaster_n),
  .all_we_n       (all_we_n),
  .op             (op_w),
  .lane_mask      (lane_mask_w),
  .drv            (drv_w)
);

// File: tb/tb_sbs_sram_core.sv
`timescale 1ns/1ps
module tb_sbs_sram_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic [17:0] wdata;
  logic        sel0_n, sel1, sel2_n;
  logic        host_strobe_n, ctrl_strobe_n, advance_n, burst_order;
  logic [1:0]  lane_we_n;
  logic        lane_wmaster_n, all_we_n, out_en_n;
  logic [17:0] rdata;
  logic        rdata_drive;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sbs_sram_core dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .host_strobe_n(host_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .advance_n(advance_n), .burst_order(burst_order),
    .lane_we_n(lane_we_n), .lane_wmaster_n(lane_wmaster_n),
    .all_we_n(all_we_n), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  localparam logic [2:0] SEL = 3'b010;  // {sel0_n, sel1, sel2_n}
  localparam logic [2:0] DES = 3'b110;

  typedef struct packed {
    logic        hs_n;
    logic        ct_n;
    logic        adv_n;
    logic [2:0]  cs;
    logic [5:0]  a;
    logic [17:0] wd;
    logic [1:0]  ln;
    logic        mst_n;
    logic        all_n;
    logic        ed;
    logic [17:0] ex;
    logic [3:0]  req;
  } vec_t;

  // Each row: command applied now; expectation = result of the row two above.
  localparam vec_t TBL [24] = '{
    '{1'b1,1'b0,1'b1,SEL,6'd5,18'h2A5A5,2'b00,1'b0,1'b1, 1'b0,18'h0,     4'd1 }, // R3 write; R1
    '{1'b1,1'b0,1'b1,SEL,6'd6,18'h15A5A,2'b11,1'b1,1'b0, 1'b0,18'h0,     4'd1 }, // R5 write; R1
    '{1'b1,1'b0,1'b1,SEL,6'd5,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd13}, // read; R13
    '{1'b1,1'b0,1'b1,SEL,6'd6,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd13},
    '{1'b1,1'b0,1'b1,SEL,6'd5,18'h3FFFF,2'b10,1'b0,1'b1, 1'b1,18'h2A5A5, 4'd3 }, // lane A; R2 R3
    '{1'b1,1'b0,1'b1,SEL,6'd6,18'h00000,2'b01,1'b0,1'b1, 1'b1,18'h15A5A, 4'd5 }, // lane B; R5
    '{1'b1,1'b0,1'b1,SEL,6'd5,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd13},
    '{1'b1,1'b0,1'b1,SEL,6'd6,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd13},
    '{1'b1,1'b0,1'b1,SEL,6'd5,18'h0,    2'b00,1'b1,1'b1, 1'b1,18'h2A5FF, 4'd4 }, // R6 no master; R4
    '{1'b0,1'b1,1'b1,SEL,6'd6,18'h3FFFF,2'b11,1'b1,1'b0, 1'b1,18'h0005A, 4'd4 }, // R9 host; R4
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h2A5FF, 4'd6 }, // R6
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h0005A, 4'd9 }, // R9
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h0005A, 4'd11}, // R11 extend
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd11}, // R11 release
    '{1'b1,1'b0,1'b1,SEL,6'd5,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd11},
    '{1'b0,1'b1,1'b0,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd11}, // R8 ignored host
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h2A5FF, 4'd2 }, // R2
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h0005A, 4'd8 }, // R8
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h0005A, 4'd11},
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd11},
    '{1'b1,1'b0,1'b1,SEL,6'd6,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd11},
    '{1'b1,1'b1,1'b1,SEL,6'd5,18'h0,    2'b11,1'b1,1'b1, 1'b0,18'h0,     4'd11}, // R7 no strobe
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h0005A, 4'd2 },
    '{1'b1,1'b0,1'b1,DES,6'd0,18'h0,    2'b11,1'b1,1'b1, 1'b1,18'h0005A, 4'd7 }  // R7
  };

  task automatic put(input logic hs, input logic ct, input logic adv,
                     input logic [2:0] cs, input logic [5:0] a,
                     input logic [17:0] wd, input logic [1:0] ln,
                     input logic mst, input logic all);
    host_strobe_n  = hs;
    ctrl_strobe_n  = ct;
    advance_n      = adv;
    {sel0_n, sel1, sel2_n} = cs;
    addr           = a;
    wdata          = wd;
    lane_we_n      = ln;
    lane_wmaster_n = mst;
    all_we_n       = all;
  endtask

  task automatic put_rd(input logic [5:0] a);
    put(1'b1, 1'b0, 1'b1, SEL, a, 18'h0, 2'b11, 1'b1, 1'b1);
  endtask

  task automatic put_des();
    put(1'b1, 1'b0, 1'b1, DES, 6'd0, 18'h0, 2'b11, 1'b1, 1'b1);
  endtask

  task automatic chk(input int req, input logic ed, input logic [17:0] ex);
    logic [17:0] want;
    want = ed ? ex : 18'h0;
    checks++;
    if (rdata_drive !== ed || rdata !== want) begin
      errors++;
      $display("FAIL R%0d: drive=%0b data=%05h expected drive=%0b data=%05h",
               req, rdata_drive, rdata, ed, want);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished (R1..)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [17:0] D0 = 18'h11111, D1 = 18'h22222;
  localparam logic [17:0] D2 = 18'h33333, D3 = 18'h04444;

  initial begin
    rst_n = 1'b0;
    out_en_n = 1'b0;
    burst_order = 1'b0;
    put(1'b1, 1'b1, 1'b1, DES, 6'd0, 18'h0, 2'b11, 1'b1, 1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(1, 1'b0, 18'h0);  // R1 during reset
    rst_n = 1'b1;

    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      chk(int'(TBL[i].req), TBL[i].ed, TBL[i].ex);
      put(TBL[i].hs_n, TBL[i].ct_n, TBL[i].adv_n, TBL[i].cs, TBL[i].a,
          TBL[i].wd, TBL[i].ln, TBL[i].mst_n, TBL[i].all_n);
    end

    // R10 linear burst of writes from base 9 wraps to 8.
    @(negedge clk); put(1'b1, 1'b0, 1'b1, SEL, 6'd9, D0, 2'b00, 1'b0, 1'b1);
    @(negedge clk); put(1'b1, 1'b1, 1'b0, SEL, 6'd0, D1, 2'b00, 1'b0, 1'b1);
    @(negedge clk); put(1'b1, 1'b1, 1'b0, SEL, 6'd0, D2, 2'b00, 1'b0, 1'b1);
    @(negedge clk); put(1'b1, 1'b1, 1'b0, SEL, 6'd0, D3, 2'b00, 1'b0, 1'b1);
    @(negedge clk); put_des();
    @(negedge clk); put_rd(6'd8);
    @(negedge clk); put_rd(6'd9);
    @(negedge clk); chk(10, 1'b1, D3); put_rd(6'd10);  // R10 wrap
    @(negedge clk); chk(10, 1'b1, D0); put_rd(6'd11);  // R10
    @(negedge clk); chk(10, 1'b1, D1); put_des();      // R10
    @(negedge clk); chk(10, 1'b1, D2); put_des(); burst_order = 1'b1;  // R10

    // R10 interleaved read burst from base 9: 9, 8, 11, 10.
    @(negedge clk); put_rd(6'd9);
    @(negedge clk); put(1'b1, 1'b1, 1'b0, SEL, 6'd0, 18'h0, 2'b11, 1'b1, 1'b1);
    @(negedge clk); chk(10, 1'b1, D0);
    put(1'b1, 1'b1, 1'b0, SEL, 6'd0, 18'h0, 2'b11, 1'b1, 1'b1);
    @(negedge clk); chk(10, 1'b1, D3);
    put(1'b1, 1'b1, 1'b0, SEL, 6'd0, 18'h0, 2'b11, 1'b1, 1'b1);
    @(negedge clk); chk(10, 1'b1, D2); put_des();
    @(negedge clk); chk(10, 1'b1, D1); put_des();

    // R12 output enable acts without a clock edge.
    out_en_n = 1'b1;
    #1 chk(12, 1'b0, 18'h0);  // R12 off
    out_en_n = 1'b0;
    #1 chk(12, 1'b1, D1);     // R12 back on

    @(negedge clk); chk(11, 1'b1, D1); put_des();  // R11 extend
    @(negedge clk); chk(11, 1'b0, 18'h0);           // R11 release
    @(negedge clk); chk(1, 1'b0, 18'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule